// File: doc/BRIEF.md
# External Bus Release Arbiter

This block decides who owns a shared external memory bus: the on-chip memory controller or an outside master. The outside master raises a request line and waits for an acknowledge. Before the block hands the bus over, it lets any external transfer already under way finish. It also closes every SDRAM bank it has seen opened, using one all-bank precharge command. While the bus is handed over, internal masters keep working. Only their accesses to external space are held in a wait state, until the outside master drops its request.

The same block chooses, cycle by cycle, which internal master drives the internal bus: the DMA engine, the data-transfer controller or the CPU, in that fixed priority order. It inserts a single idle cycle in two cases. The first is when ownership moves to the DMA engine. The second is when a CPU access to internal I/O is directly followed by a CPU access to external space, unless the CPU external-priority input is set. A switch to the data-transfer controller never costs a cycle.

Top module: `ext_bus_release_arb`

## Requirements
- R1: When a bus request is sampled while at least one bank is open and no external access is busy, `pall_o` is high for exactly one cycle, starting the cycle after that sampling edge. Precharge then lasts PALL_CYC cycles.
- R2: `back_o` rises on the cycle after the precharge period ends, which is PALL_CYC+1 cycles after the request was sampled. It is never high while `pall_o` is high, and it never rises while a bank is still marked open.
- R3: With no bank open and no external access busy, a sampled request raises `back_o` on the next cycle and no precharge is issued.
- R4: A request sampled while `ext_busy_i` is high is held: `back_o` and `pall_o` stay low until `ext_busy_i` is sampled low. The precharge or the acknowledge then follows as in R1 and R3.
- R5: A bank-open mask holds one bit per bank. A pulse on `bank_act_i` sets the bit selected by `bank_act_id_i`. Any all-bank precharge clears every bit, whether it is the block's own `pall_o` or the controller's `ctl_pall_i`. Clearing wins over setting when both happen in the same cycle.
- R6: While a release is pending or in force, a winning access whose `mst_ext_i` bit is 0 is granted with no stall.
- R7: While a release is pending or in force, a winning access whose `mst_ext_i` bit is 1 gets `stall_o`=1 and no grant.
- R8: When `breq_i` is sampled low during a release, `back_o` falls on the next cycle. A stalled external access is granted on the cycle after that.
- R9: When the DMA engine (bit 2) wins and the previous owner was not the DMA engine, that cycle is idle: `idle_o`=1 and no grant. The DMA engine is granted from the next cycle on.
- R10: When the data-transfer controller (bit 1) wins, it is granted at once, with no idle cycle.
- R11: When the CPU (bit 0) makes an external access in the cycle directly after a granted CPU access with `cpu_io_i`=1 and `cpu_ext_prio_i`=0, that cycle is idle. With `cpu_ext_prio_i`=1 no idle cycle is inserted.
- R12: Priority is DMA over data-transfer controller over CPU, and `grant_o` is one-hot or zero.
- R13: After reset, `back_o`, `pall_o`, `grant_o`, `idle_o` and `stall_o` are all 0 and no bank is marked open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| breq_i | input | 1 | Bus request from the outside master |
| back_o | output | 1 | Bus handed to the outside master |
| ext_busy_i | input | 1 | An external access is in progress |
| bank_act_i | input | 1 | Bank activate issued by the controller |
| bank_act_id_i | input | ID_W | Bank being activated |
| ctl_pall_i | input | 1 | All-bank precharge issued by the controller |
| pall_o | output | 1 | All-bank precharge command issued before a release |
| mst_req_i | input | 3 | Requests: bit 0 CPU, bit 1 transfer controller, bit 2 DMA |
| mst_ext_i | input | 3 | The matching request targets external space |
| cpu_io_i | input | 1 | The CPU access targets internal I/O |
| cpu_ext_prio_i | input | 1 | 1 removes the idle cycle between CPU I/O and external accesses |
| grant_o | output | 3 | One-hot grant to the winning master |
| idle_o | output | 1 | This cycle is an inserted idle cycle |
| stall_o | output | 1 | The winner waits for the bus to come back |

## Verification
The bench builds the block with four banks and a two-cycle precharge period. This keeps the count from request to acknowledge short enough to check every cycle of the precharge, while still using the multi-cycle counter variant rather than the single-cycle one. With four banks the bench can open a bank above bit 0 and an upper bank separately, and can show that both the block's own precharge and the controller's precharge clear the whole mask. The table walk covers the winner and idle-cycle sequence; the directed tests cover the release, the drain of a busy access and the return of the bus.

// File: rtl/ebr_pkg.sv
package ebr_pkg;
   localparam int NUM_MST = 3;
   localparam int IX_CPU = 0;
   localparam int IX_DTC = 1;
   localparam int IX_DMA = 2;

   typedef enum logic [1:0] {
      MST_CPU  = 2'd0,
      MST_DTC  = 2'd1,
      MST_DMA  = 2'd2,
      MST_NONE = 2'd3
   } mst_e;

   typedef enum logic [2:0] {
      REL_OWN,
      REL_DRAIN,
      REL_PRE,
      REL_GIVEN,
      REL_RETURN
   } rel_state_e;
endpackage

// File: rtl/ebr_bank_tracker.sv
module ebr_bank_tracker #(
   parameter int NUM_BANKS = 4,
   localparam int ID_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 act_i,
   input  logic [ID_W-1:0]      act_id_i,
   input  logic                 clr_i,
   output logic [NUM_BANKS-1:0] open_o,
   output logic                 any_open_o
);
   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            open_o[b] <= 1'b0;
         else if (clr_i)
            open_o[b] <= 1'b0;
         else if (act_i && (act_id_i == ID_W'(b)))
            open_o[b] <= 1'b1;
      end
   end

   assign any_open_o = |open_o;
endmodule

// File: rtl/ebr_release_fsm.sv
module ebr_release_fsm
   import ebr_pkg::*;
#(
   parameter int PALL_CYC = 3,
   localparam int CNT_W = (PALL_CYC > 1) ? $clog2(PALL_CYC) : 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic breq_i,
   input  logic ext_busy_i,
   input  logic any_open_i,
   output logic pall_o,
   output logic back_o,
   output logic ext_block_o
);
   rel_state_e state_q, state_d;
   logic       pre_done;
   logic       pall_q;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         REL_OWN: begin
            if (breq_i) begin
               if (ext_busy_i)      state_d = REL_DRAIN;
               else if (any_open_i) state_d = REL_PRE;
               else                 state_d = REL_GIVEN;
            end
         end
         REL_DRAIN: begin
            if (!ext_busy_i) state_d = any_open_i ? REL_PRE : REL_GIVEN;
         end
         REL_PRE:    if (pre_done) state_d = REL_GIVEN;
         REL_GIVEN:  if (!breq_i)  state_d = REL_RETURN;
         REL_RETURN: state_d = REL_OWN;
         default:    state_d = REL_OWN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= REL_OWN;
         pall_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         pall_q  <= (state_d == REL_PRE) && (state_q != REL_PRE);
      end
   end

   if (PALL_CYC > 1) begin : g_pre_cnt
      logic [CNT_W-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cnt_q <= '0;
         else if ((state_d == REL_PRE) && (state_q != REL_PRE))
            cnt_q <= CNT_W'(PALL_CYC - 1);
         else if ((state_q == REL_PRE) && (cnt_q != '0))
            cnt_q <= cnt_q - 1'b1;
      end
      assign pre_done = (cnt_q == '0);
   end else begin : g_pre_one
      assign pre_done = 1'b1;
   end

   assign pall_o      = pall_q;
   assign back_o      = (state_q == REL_GIVEN);
   assign ext_block_o = (state_q != REL_OWN);
endmodule

// File: rtl/ebr_master_sel.sv
module ebr_master_sel
   import ebr_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_MST-1:0] req_i,
   input  logic [NUM_MST-1:0] ext_i,
   input  logic               cpu_io_i,
   input  logic               cpu_ext_prio_i,
   input  logic               ext_block_i,
   output logic [NUM_MST-1:0] grant_o,
   output logic               idle_o,
   output logic               stall_o
);
   mst_e win;
   mst_e owner_q;
   logic io_last_q;
   logic win_ext;
   logic idle_dma, idle_cpu;

   always_comb begin
      win     = MST_NONE;
      win_ext = 1'b0;
      if (req_i[IX_DMA]) begin
         win     = MST_DMA;
         win_ext = ext_i[IX_DMA];
      end else if (req_i[IX_DTC]) begin
         win     = MST_DTC;
         win_ext = ext_i[IX_DTC];
      end else if (req_i[IX_CPU]) begin
         win     = MST_CPU;
         win_ext = ext_i[IX_CPU];
      end
   end

   assign stall_o  = win_ext && ext_block_i;
   assign idle_dma = (win == MST_DMA) && (owner_q != MST_DMA) && !stall_o;
   assign idle_cpu = (win == MST_CPU) && win_ext && io_last_q
                     && !cpu_ext_prio_i && !stall_o;
   assign idle_o   = idle_dma || idle_cpu;

   always_comb begin
      grant_o = '0;
      if ((win != MST_NONE) && !stall_o && !idle_o)
         grant_o = NUM_MST'(1) << win;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         owner_q   <= MST_NONE;
         io_last_q <= 1'b0;
      end else begin
         if (idle_dma)
            owner_q <= MST_DMA;
         else if (|grant_o)
            owner_q <= win;
         io_last_q <= grant_o[IX_CPU] && cpu_io_i && !ext_i[IX_CPU];
      end
   end
endmodule

// File: rtl/ext_bus_release_arb.sv
module ext_bus_release_arb
   import ebr_pkg::*;
#(
   parameter int NUM_BANKS = 4,
   parameter int PALL_CYC  = 3,
   localparam int ID_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               breq_i,
   output logic               back_o,
   input  logic               ext_busy_i,
   input  logic               bank_act_i,
   input  logic [ID_W-1:0]    bank_act_id_i,
   input  logic               ctl_pall_i,
   output logic               pall_o,
   input  logic [NUM_MST-1:0] mst_req_i,
   input  logic [NUM_MST-1:0] mst_ext_i,
   input  logic               cpu_io_i,
   input  logic               cpu_ext_prio_i,
   output logic [NUM_MST-1:0] grant_o,
   output logic               idle_o,
   output logic               stall_o
);
   if (NUM_BANKS < 1 || NUM_BANKS > 16) begin : g_bad_banks
      $error("NUM_BANKS must lie in 1..16");
   end
   if (PALL_CYC < 1) begin : g_bad_pall
      $error("PALL_CYC must be at least 1");
   end

   logic [NUM_BANKS-1:0] open_mask;
   logic                 any_open;
   logic                 ext_block;

   ebr_bank_tracker #(.NUM_BANKS(NUM_BANKS)) u_banks (
      .clk        (clk),
      .rst_n      (rst_n),
      .act_i      (bank_act_i),
      .act_id_i   (bank_act_id_i),
      .clr_i      (pall_o | ctl_pall_i),
      .open_o     (open_mask),
      .any_open_o (any_open)
   );

   ebr_release_fsm #(.PALL_CYC(PALL_CYC)) u_rel (
      .clk         (clk),
      .rst_n       (rst_n),
      .breq_i      (breq_i),
      .ext_busy_i  (ext_busy_i),
      .any_open_i  (any_open),
      .pall_o      (pall_o),
      .back_o      (back_o),
      .ext_block_o (ext_block)
   );

   ebr_master_sel u_sel (
      .clk            (clk),
      .rst_n          (rst_n),
      .req_i          (mst_req_i),
      .ext_i          (mst_ext_i),
      .cpu_io_i       (cpu_io_i),
      .cpu_ext_prio_i (cpu_ext_prio_i),
      .ext_block_i    (ext_block),
      .grant_o        (grant_o),
      .idle_o         (idle_o),
      .stall_o        (stall_o)
   );
endmodule

// File: rtl/ebr_arb_chk.sv
module ebr_arb_chk
   import ebr_pkg::*;
#(
   parameter int NUM_BANKS = 4
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 breq_i,
   input logic                 back_o,
   input logic                 pall_o,
   input logic                 ext_busy_i,
   input logic [NUM_MST-1:0]   mst_ext_i,
   input logic [NUM_MST-1:0]   grant_o,
   input logic                 idle_o,
   input logic                 stall_o,
   input logic [NUM_BANKS-1:0] open_mask
);
   a_r1_single_pall: assert property (@(posedge clk) disable iff (!rst_n)
      pall_o |=> !pall_o);

   a_r2_no_ack_in_pall: assert property (@(posedge clk) disable iff (!rst_n)
      pall_o |-> !back_o);

   a_r2_ack_banks_closed: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(back_o) |-> (open_mask == '0));

   a_r4_pall_after_drain: assert property (@(posedge clk) disable iff (!rst_n)
      pall_o |-> !$past(ext_busy_i));

   a_r7_no_ext_grant_released: assert property (@(posedge clk) disable iff (!rst_n)
      (|(grant_o & mst_ext_i)) |-> !back_o);

   a_r8_ack_drop_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(back_o) |-> !$past(breq_i));

   a_r9_idle_no_grant: assert property (@(posedge clk) disable iff (!rst_n)
      idle_o |-> ((grant_o == '0) && !stall_o));

   a_r12_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant_o));
endmodule

bind ext_bus_release_arb ebr_arb_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .breq_i     (breq_i),
   .back_o     (back_o),
   .pall_o     (pall_o),
   .ext_busy_i (ext_busy_i),
   .mst_ext_i  (mst_ext_i),
   .grant_o    (grant_o),
   .idle_o     (idle_o),
   .stall_o    (stall_o),
   .open_mask  (open_mask)
);

// File: tb/sim_ext_bus_release_arb.sv
`timescale 1ns/1ps
module sim_ext_bus_release_arb;
   localparam int NB = 4;
   localparam int PC = 2;
   localparam int IW = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic breq = 0, ext_busy = 0, act = 0, ctl_pall = 0;
   logic [IW-1:0] act_id = '0;
   logic [2:0] req = '0, ext = '0;
   logic io = 0, prio = 0;
   logic back, pall, idle, stall;
   logic [2:0] grant;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   ext_bus_release_arb #(.NUM_BANKS(NB), .PALL_CYC(PC)) u0 (
      .clk(clk), .rst_n(rst_n), .breq_i(breq), .back_o(back),
      .ext_busy_i(ext_busy), .bank_act_i(act), .bank_act_id_i(act_id),
      .ctl_pall_i(ctl_pall), .pall_o(pall), .mst_req_i(req),
      .mst_ext_i(ext), .cpu_io_i(io), .cpu_ext_prio_i(prio),
      .grant_o(grant), .idle_o(idle), .stall_o(stall)
   );

   // fields: [16:13] requirement, [12:10] req, [9:7] ext, [6] io, [5] prio,
   //         [4:2] grant, [1] idle, [0] stall
   localparam logic [16:0] VEC [14] = '{
      {4'd11, 3'b001, 3'b000, 1'b1, 1'b0, 3'b001, 1'b0, 1'b0}, // R11 CPU I/O
      {4'd11, 3'b001, 3'b001, 1'b0, 1'b0, 3'b000, 1'b1, 1'b0}, // R11 idle
      {4'd11, 3'b001, 3'b001, 1'b0, 1'b0, 3'b001, 1'b0, 1'b0}, // R11 then grant
      {4'd11, 3'b001, 3'b000, 1'b1, 1'b1, 3'b001, 1'b0, 1'b0}, // R11 I/O, prio 1
      {4'd11, 3'b001, 3'b001, 1'b0, 1'b1, 3'b001, 1'b0, 1'b0}, // R11 no idle
      {4'd9,  3'b100, 3'b000, 1'b0, 1'b0, 3'b000, 1'b1, 1'b0}, // R9 switch idle
      {4'd9,  3'b100, 3'b000, 1'b0, 1'b0, 3'b100, 1'b0, 1'b0}, // R9 then grant
      {4'd12, 3'b110, 3'b000, 1'b0, 1'b0, 3'b100, 1'b0, 1'b0}, // R12 DMA wins
      {4'd10, 3'b010, 3'b000, 1'b0, 1'b0, 3'b010, 1'b0, 1'b0}, // R10 no idle
      {4'd10, 3'b011, 3'b000, 1'b0, 1'b0, 3'b010, 1'b0, 1'b0}, // R10 over CPU
      {4'd9,  3'b100, 3'b000, 1'b0, 1'b0, 3'b000, 1'b1, 1'b0}, // R9 again
      {4'd12, 3'b101, 3'b000, 1'b0, 1'b0, 3'b100, 1'b0, 1'b0}, // R12
      {4'd12, 3'b001, 3'b000, 1'b0, 1'b0, 3'b001, 1'b0, 1'b0}, // R12 CPU alone
      {4'd12, 3'b000, 3'b000, 1'b0, 1'b0, 3'b000, 1'b0, 1'b0}  // R12 none
   };

   task automatic chk(input string tag, input int act_v, input int exp_v);
      checks++;
      if (act_v != exp_v) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act_v, exp_v);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic release_bus();
      breq = 0;
      step();
      step();
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R13 back", int'(back), 0);
      chk("R13 pall", int'(pall), 0);
      chk("R13 grant", int'(grant), 0);
      chk("R13 idle", int'(idle), 0);
      rst_n = 1'b1;
      step();
      chk("R13 stall", int'(stall), 0);

      for (int i = 0; i < 14; i++) begin
         req  = VEC[i][12:10];
         ext  = VEC[i][9:7];
         io   = VEC[i][6];
         prio = VEC[i][5];
         #1;
         chk($sformatf("R%0d grant vec%0d", VEC[i][16:13], i), int'(grant), int'(VEC[i][4:2]));
         chk($sformatf("R%0d idle vec%0d", VEC[i][16:13], i), int'(idle), int'(VEC[i][1]));
         chk($sformatf("R%0d stall vec%0d", VEC[i][16:13], i), int'(stall), int'(VEC[i][0]));
         step();
      end
      req = '0; ext = '0; io = 0; prio = 0;

      // R3: no open bank, direct handover
      breq = 1;
      step();
      chk("R3 back", int'(back), 1);
      chk("R3 pall", int'(pall), 0);
      // R6 / R7 while released
      req = 3'b001; ext = 3'b000;
      #1;
      chk("R6 grant", int'(grant), 1);
      chk("R6 stall", int'(stall), 0);
      ext = 3'b001;
      #1;
      chk("R7 stall", int'(stall), 1);
      chk("R7 grant", int'(grant), 0);
      // R8 return
      breq = 0;
      step();
      chk("R8 back drop", int'(back), 0);
      chk("R8 still stalled", int'(stall), 1);
      step();
      chk("R8 resume grant", int'(grant), 1);
      chk("R8 resume stall", int'(stall), 0);
      req = '0; ext = '0;
      step();

      // R1 / R2: open bank 2, precharge before handover
      act = 1; act_id = 2'd2;
      step();
      act = 0; breq = 1;
      step();
      chk("R1 pall first", int'(pall), 1);
      chk("R2 back during pall", int'(back), 0);
      step();
      chk("R1 pall single", int'(pall), 0);
      chk("R2 back early", int'(back), 0);
      step();
      chk("R2 back after pall", int'(back), 1);
      release_bus();
      // R5: own precharge cleared the mask
      breq = 1;
      step();
      chk("R5 mask cleared back", int'(back), 1);
      chk("R5 mask cleared pall", int'(pall), 0);
      release_bus();

      // R5: controller precharge clears the mask
      act = 1; act_id = 2'd1;
      step();
      act = 0; ctl_pall = 1;
      step();
      ctl_pall = 0; breq = 1;
      step();
      chk("R5 ctl clear back", int'(back), 1);
      chk("R5 ctl clear pall", int'(pall), 0);
      release_bus();

      // R4: drain a busy access, with bank 3 open
      act = 1; act_id = 2'd3;
      step();
      act = 0; ext_busy = 1; breq = 1;
      for (int k = 0; k < 3; k++) begin
         step();
         chk("R4 back held", int'(back), 0);
         chk("R4 pall held", int'(pall), 0);
      end
      ext_busy = 0;
      step();
      chk("R4 pall after drain", int'(pall), 1);
      step();
      step();
      chk("R4 back after drain", int'(back), 1);
      release_bus();

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule